// File: doc/BRIEF.md
# Tenths-of-a-Second Stopwatch Core

This block measures elapsed time as minutes, seconds and tenths of a second, shown as MM:SS:t. Its time base is a one-cycle enable pulse that arrives ten times per second. Each pulse moves the count forward by one tenth while the watch is running. The block is clocked by the system clock. The enable pulse is made elsewhere.

Three push buttons control it: go, hold and clear. All three are active low. Each button is synchronised, inverted and edge-detected inside the block, so one press acts once however long the button is held. A small state machine has three states: stopped, running and held. It gates a chain of five BCD digit counters, and each digit steps only when every lower digit rolls over.

The five digits come out as 4-bit values. The block also drives a running flag and one active-low seven-segment pattern for each digit, ready for a common-anode display.

Top module: `stopwatch_core`

## Requirements
- R1: `tenths`, `sec_ones` and `min_ones` take only the values 0 to 9. `sec_tens` and `min_tens` take only 0 to 5, so the largest reading is 59:59:9.
- R2: While running, each cycle with `tick` high adds one tenth to the count. A digit steps only when every lower digit is at its top value, and it then returns to 0. Its top value is 9 for the units and tenths digits and 5 for the tens digits.
- R3: A tick while running at 59:59:9 returns all five digits to 0 and keeps the watch running.
- R4: A button press is the first clock edge at which the pin is sampled low after being high. The press takes effect at the third rising edge from that sample and is visible after that edge. Holding a pin low gives only one press.
- R5: A go press in the stopped or held state starts running, and counting continues from the digits held. A go press while running has no effect.
- R6: A hold press while running enters the held state. There the digits keep their value and ticks are ignored.
- R7: A clear press in any state sets all digits to 0 and enters the stopped state. It wins over a go or hold press that takes effect in the same cycle.
- R8: In the stopped state ticks are ignored, and a hold press has no effect.
- R9: `seg_n` carries seven bits per digit: tenths at bits 6:0, then `sec_ones`, `sec_tens`, `min_ones`, and `min_tens` at bits 34:28. Within a digit, bit 0 is segment a through bit 6 is segment g, and a lit segment is driven 0. The lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R10: An active-low asynchronous `rst_n` clears all digits, enters the stopped state and forgets any button history.
- R11: `running` is 1 exactly when the state machine is in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Ten-per-second enable pulse, one cycle wide |
| start_n | input | 1 | Go button, active low |
| pause_n | input | 1 | Hold button, active low |
| clear_n | input | 1 | Clear button, active low |
| tenths | output | 4 | Tenths-of-a-second digit |
| sec_ones | output | 4 | Seconds units digit |
| sec_tens | output | 4 | Seconds tens digit |
| min_ones | output | 4 | Minutes units digit |
| min_tens | output | 4 | Minutes tens digit |
| running | output | 1 | High while counting is enabled |
| seg_n | output | 35 | Active-low segment patterns for the five digits |

## Verification
The assertions check on every cycle that:
- each digit stays within its range;
- a tick while running steps the tenths digit and leaves the upper digits still unless tenths rolls over;
- a full reading wraps to zero;
- a clear press leaves zeros in the stopped state;
- nothing moves while the watch is not running.

Some behaviours only the bench's scenarios can show:
- the three-edge press latency and the single action of a held button;
- the choice between held and stopped, which the `running` flag alone does not reveal;
- resuming from the held value;
- the clear-over-go priority;
- the segment encoding.

A behavioural reference model counts in tenths and derives the digits by division. The bench compares it against every output on every clock.

// File: rtl/stopwatch_core.sv
module stopwatch_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start_n,
  input  logic        pause_n,
  input  logic        clear_n,
  output logic [3:0]  tenths,
  output logic [3:0]  sec_ones,
  output logic [3:0]  sec_tens,
  output logic [3:0]  min_ones,
  output logic [3:0]  min_tens,
  output logic        running,
  output logic [34:0] seg_n
);
  localparam int NDIG = 5;
  localparam int SEGW = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} state_t;

  state_t               state;
  logic [2:0]           meta, sync, prev;
  logic                 go_p, hold_p, clr_p;
  logic [NDIG:0]        carry;
  logic [4*NDIG-1:0]    dig;

  function automatic logic [6:0] seg_on(input logic [3:0] d);
    case (d)
      4'd0: seg_on = 7'h3F;
      4'd1: seg_on = 7'h06;
      4'd2: seg_on = 7'h5B;
      4'd3: seg_on = 7'h4F;
      4'd4: seg_on = 7'h66;
      4'd5: seg_on = 7'h6D;
      4'd6: seg_on = 7'h7D;
      4'd7: seg_on = 7'h07;
      4'd8: seg_on = 7'h7F;
      4'd9: seg_on = 7'h6F;
      default: seg_on = 7'h00;
    endcase
  endfunction

  // buttons: bit 0 go, bit 1 hold, bit 2 clear; two-flop sync then edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= ~{clear_n, pause_n, start_n};
      sync <= meta;
      prev <= sync;
    end
  end

  assign {clr_p, hold_p, go_p} = sync & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= ST_IDLE;
    else if (clr_p)  state <= ST_IDLE;
    else begin
      case (state)
        ST_RUN:  if (hold_p) state <= ST_HOLD;
        default: if (go_p)   state <= ST_RUN;
      endcase
    end
  end

  assign carry[0] = (state == ST_RUN) && tick;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    localparam logic [3:0] LIM = (g == 2 || g == 4) ? 4'd5 : 4'd9;
    logic [3:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (clr_p)      q <= '0;
      else if (carry[g])   q <= (q == LIM) ? 4'd0 : q + 4'd1;
    end

    assign carry[g+1]             = carry[g] && (q == LIM);
    assign dig[4*g +: 4]          = q;
    assign seg_n[SEGW*g +: SEGW]  = ~seg_on(q);
  end

  assign tenths   = dig[3:0];
  assign sec_ones = dig[7:4];
  assign sec_tens = dig[11:8];
  assign min_ones = dig[15:12];
  assign min_tens = dig[19:16];
  assign running  = (state == ST_RUN);
endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       running,
  input logic       clr_p,
  input logic [3:0] tenths,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens
);
  logic [19:0] all_d;
  logic [15:0] upper_d;
  assign all_d   = {min_tens, min_ones, sec_tens, sec_ones, tenths};
  assign upper_d = {min_tens, min_ones, sec_tens, sec_ones};

  p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tenths <= 4'd9 && sec_ones <= 4'd9 && sec_tens <= 4'd5 &&
    min_ones <= 4'd9 && min_tens <= 4'd5);

  p_tenths_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !clr_p) |=>
      tenths == (($past(tenths) == 4'd9) ? 4'd0 : $past(tenths) + 4'd1));

  p_no_early_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !clr_p && tenths != 4'd9) |=> $stable(upper_d));

  p_full_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !clr_p && all_d == 20'h59599) |=> (all_d == 20'h0 && running));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> (all_d == 20'h0 && !running));

  // held (R6) and stopped (R8) states both freeze the digits
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr_p) |=> $stable(all_d));

  p_no_tick_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !clr_p) |=> $stable(all_d));
endmodule

bind stopwatch_core stopwatch_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .running  (running),
  .clr_p    (clr_p),
  .tenths   (tenths),
  .sec_ones (sec_ones),
  .sec_tens (sec_tens),
  .min_ones (min_ones),
  .min_tens (min_tens)
);

// File: tb/stopwatch_core_tb.sv
module stopwatch_core_tb;
  logic clk = 1'b0;
  logic rst_n, tick, start_n, pause_n, clear_n;
  logic [3:0] tenths, sec_ones, sec_tens, min_ones, min_tens;
  logic running;
  logic [34:0] seg_n;

  always #10 clk = ~clk;

  stopwatch_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_n(start_n), .pause_n(pause_n), .clear_n(clear_n),
    .tenths(tenths), .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens),
    .running(running), .seg_n(seg_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] lit(input int d);
    string s;
    logic [6:0] v = '0;
    case (d)
      0: s = "abcdef";  1: s = "bc";      2: s = "abdeg";   3: s = "abcdg";
      4: s = "bcfg";    5: s = "acdfg";   6: s = "acdefg";  7: s = "abc";
      8: s = "abcdefg"; default: s = "abcdfg";
    endcase
    for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
    return v;
  endfunction

  // reference model: count in tenths, state 0 stopped / 1 running / 2 held
  int mcnt, mst;
  logic [2:0] hs, hp, hc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; mst = 0; hs = '0; hp = '0; hc = '0;
    end else begin
      bit ps, pp, pc;
      ps = hs[1] && !hs[2];
      pp = hp[1] && !hp[2];
      pc = hc[1] && !hc[2];
      if (pc) begin
        mcnt = 0; mst = 0;
      end else begin
        if (mst == 1 && tick) mcnt = (mcnt + 1) % 36000;
        if (mst == 1 && pp) mst = 2;
        else if (mst != 1 && ps) mst = 1;
      end
      hs = {hs[1:0], !start_n};
      hp = {hp[1:0], !pause_n};
      hc = {hc[1:0], !clear_n};
    end
  end

  function automatic logic [19:0] model_digits();
    return {4'(mcnt / 6000), 4'((mcnt / 600) % 10), 4'((mcnt / 100) % 6),
            4'((mcnt / 10) % 10), 4'(mcnt % 10)};
  endfunction

  function automatic logic [34:0] segs_for(input logic [19:0] d);
    logic [34:0] v;
    for (int i = 0; i < 5; i++) v[7*i +: 7] = ~lit(int'(d[4*i +: 4]));
    return v;
  endfunction

  logic [19:0] dut_d;
  assign dut_d = {min_tens, min_ones, sec_tens, sec_ones, tenths};

  always @(negedge clk) begin
    if (!finished) begin
      chk(dut_d == model_digits(), "R2 digits vs model", dut_d, model_digits());
      chk(running == (mst == 1), "R11 running vs model", running, mst == 1);
      chk(seg_n == segs_for(model_digits()), "R9 segments vs model", seg_n, segs_for(model_digits()));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  task automatic press_start(); start_n = 0; @(negedge clk); start_n = 1; repeat (3) @(negedge clk); endtask
  task automatic press_pause(); pause_n = 0; @(negedge clk); pause_n = 1; repeat (3) @(negedge clk); endtask
  task automatic press_clear(); clear_n = 0; @(negedge clk); clear_n = 1; repeat (3) @(negedge clk); endtask

  initial begin
    rst_n = 0; tick = 0; start_n = 1; pause_n = 1; clear_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dut_d == 20'h0, "R10 reset digits", dut_d, 20'h0);
    chk(running == 1'b0, "R10 reset stopped", running, 0);
    chk(seg_n == {5{~7'h3F}}, "R9 zero pattern", seg_n, {5{~7'h3F}});

    tick = 1; repeat (10) @(negedge clk); tick = 0;
    chk(dut_d == 20'h0, "R8 ticks ignored when stopped", dut_d, 20'h0);
    pause_n = 0; repeat (2) @(negedge clk); pause_n = 1; repeat (4) @(negedge clk);
    chk(running == 1'b0, "R8 hold press while stopped", running, 0);

    start_n = 0;
    @(negedge clk); @(negedge clk);
    chk(running == 1'b0, "R4 no effect before third edge", running, 0);
    @(negedge clk);
    chk(running == 1'b1, "R4 effect at third edge", running, 1);

    repeat (25) begin tick = 1; @(negedge clk); tick = 0; @(negedge clk); end
    chk(dut_d == 20'h00025, "R2 sparse ticks", dut_d, 20'h00025);
    chk(seg_n[6:0] == ~7'h6D, "R9 digit 5 pattern", seg_n[6:0], ~7'h6D);
    chk(seg_n[13:7] == ~7'h5B, "R9 digit 2 pattern", seg_n[13:7], ~7'h5B);

    pause_n = 0; repeat (3) @(negedge clk);
    chk(running == 1'b0, "R6 hold press", running, 0);
    pause_n = 1;
    tick = 1; repeat (10) @(negedge clk); tick = 0;
    chk(dut_d == 20'h00025, "R6 held digits", dut_d, 20'h00025);
    chk(running == 1'b0, "R4 held go pin acts once", running, 0);

    start_n = 1; repeat (3) @(negedge clk);
    press_start();
    chk(running == 1'b1, "R5 resume", running, 1);
    tick = 1; repeat (5) @(negedge clk); tick = 0;
    chk(dut_d == 20'h00030, "R5 continues from held value", dut_d, 20'h00030);

    tick = 1; repeat (35969) @(negedge clk); tick = 0;
    chk(dut_d == 20'h59599, "R1 top reading", dut_d, 20'h59599);
    @(negedge clk);
    tick = 1; @(negedge clk); tick = 0;
    chk(dut_d == 20'h0, "R3 wrap to zero", dut_d, 20'h0);
    chk(running == 1'b1, "R3 still running after wrap", running, 1);

    tick = 1; clear_n = 0; start_n = 0; @(negedge clk);
    clear_n = 1; start_n = 1; repeat (3) @(negedge clk); tick = 0;
    chk(dut_d == 20'h0, "R7 clear wins over go", dut_d, 20'h0);
    chk(running == 1'b0, "R7 stopped after clear", running, 0);

    press_start();
    tick = 1; repeat (7) @(negedge clk); tick = 0;
    press_pause();
    press_clear();
    chk(dut_d == 20'h0, "R7 clear from held", dut_d, 20'h0);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk(dut_d == 20'h0, "R7 stopped, not held", dut_d, 20'h0);

    press_start();
    tick = 1; repeat (12) @(negedge clk);
    #3 rst_n = 0;
    #1 chk(dut_d == 20'h0, "R10 async clear", dut_d, 20'h0);
    chk(running == 1'b0, "R10 async stop", running, 0);
    tick = 0;
    @(negedge clk); #2 rst_n = 1;
    repeat (2) @(negedge clk);
    chk(running == 1'b0, "R10 stays stopped", running, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule